// File: doc/BRIEF.md
# DMA Channel End-of-Process Controller

This block decides when a DMA service on one of several channels is over and applies what follows from that. Each channel holds a base and a current address and a base and a current word count. Each completed transfer steps the serviced channel: the current address goes up by one and the current count goes down by one. A transfer made while the count is zero is the last one. That is terminal count, and the block answers it with a one-cycle drive request on an active-low, open-drain end-of-process line.

A service can also be ended from outside by pulling the same line low. The line is synchronised through two flip-flops. While the block drives the line, and for the cycles its own pulse takes to come back through the synchroniser, the line is not taken as an outside request.

Whatever ends the service, the block then does four things for the ending channel:

- It clears the channel's request.
- It sets the channel's terminal-count status bit.
- With autoinitialize enabled, it copies the base registers into the current ones and leaves the mask bit alone.
- With autoinitialize disabled, it sets the mask bit.

Bus timing and priority arbitration sit outside this block. The serviced channel arrives as `act_valid`/`act_ch`, and each completed transfer arrives as a one-cycle `xfer_stb`.

Top module: `dma_eop_ctrl`

## Requirements
- R1: A `xfer_stb` with `act_valid` high adds one to the current address of channel `act_ch` and subtracts one from its current count. The registers of every other channel keep their values.
- R2: A strobe that finds the current count at zero is terminal count. Without autoinitialize the count becomes all ones. `eop_oe` is high in exactly the cycle after that clock edge and is low after any edge that saw no terminal count.
- R3: When a service ends, the request bit of the ending channel reads 0 after that edge. This holds even if `req_set` set the same bit in the same cycle.
- R4: When a service ends on a channel with autoinitialize enabled, its current address and current count take the base values. This applies to both terminal count and the external end, and the reload takes priority over the step of that transfer.
- R5: When a service ends, the ending channel's bit in `tc_status` is set. A `status_rd` pulse clears all of `tc_status`, but a bit set in the same cycle stays set.
- R6: When a service ends, the ending channel's bit in `mask_o` is set if autoinitialize is disabled and keeps its value if autoinitialize is enabled.
- R7: With `m2m_en` high, a strobe with `act_valid` high decrements the count of channel 1 only and increments the addresses of channels 0 and 1. The end applies to channel 1, and the requests of channels 0 and 1 are both cleared.
- R8: `eop_n_in` held low for one cycle, with `act_valid` high, ends the service at the third rising edge after it goes low. This end leaves `eop_oe` low. The same pulse with `act_valid` low changes nothing.
- R9: While `eop_oe` is high, and for the two cycles after, a low level at the synchroniser output does not end a service. The block's own pulse therefore never ends a service a second time.
- R10: After reset, all `mask_o` bits are 1, and `tc_status`, `req_o` and `eop_oe` are 0. All address and count registers are 0.
- R11: `cfg_we` writes `cfg_wdata` into both the base and the current register of channel `cfg_ch`. `cfg_sel`=0 selects the address and `cfg_sel`=1 selects the count. `rd_addr`/`rd_cnt` show the current registers of channel `rd_ch`. A write takes priority over a step or reload in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Write base and current register |
| cfg_ch | input | CH_W | Channel to write |
| cfg_sel | input | 1 | 0 address, 1 count |
| cfg_wdata | input | DATA_W | Write data |
| mode_we | input | 1 | Write autoinitialize enable |
| mode_ch | input | CH_W | Channel for mode write |
| mode_autoinit | input | 1 | Autoinitialize enable value |
| m2m_en | input | 1 | Memory-to-memory mode |
| mask_we | input | 1 | Write one mask bit |
| mask_ch | input | CH_W | Channel for mask write |
| mask_val | input | 1 | Mask bit value |
| req_set | input | NUM_CH | Set request bits |
| act_valid | input | 1 | A service is active |
| act_ch | input | CH_W | Serviced channel |
| xfer_stb | input | 1 | One transfer completed |
| eop_n_in | input | 1 | End-of-process line level, active low |
| status_rd | input | 1 | Status read, clears terminal-count bits |
| rd_ch | input | CH_W | Channel shown on read outputs |
| rd_addr | output | DATA_W | Current address of `rd_ch` |
| rd_cnt | output | DATA_W | Current count of `rd_ch` |
| eop_oe | output | 1 | Pull end-of-process line low |
| tc_status | output | NUM_CH | Terminal-count status bits |
| mask_o | output | NUM_CH | Mask bits |
| req_o | output | NUM_CH | Request bits |

## Verification
The bench targets the last transfer at count zero. A design that decrements before testing for zero ends one transfer early, and one that forgets to wrap the count holds it at zero. It drives the open-drain line through a pull-up model, so the block's own pulse echoes back. A design without blanking then ends the service a second time, and the bit that `status_rd` cleared comes back. It hits the collisions of a request set, a status read or a mask write with an end in the same cycle, where a wrong priority loses the end's effect. It tests memory-to-memory mode, where a design that ends the serviced channel instead of channel 1 leaves channel 1 unmasked.

// File: rtl/dma_eop_pkg.sv
package dma_eop_pkg;

    // Target of a configuration write
    typedef enum logic {
        SEL_ADDR  = 1'b0,
        SEL_COUNT = 1'b1
    } cfg_sel_e;

    // Channel whose count drives the end in memory-to-memory mode
    localparam int unsigned M2M_DST_CH = 1;
    localparam int unsigned M2M_SRC_CH = 0;

endpackage

// File: rtl/dma_eop_sync.sv
module dma_eop_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    input  logic drive,
    output logic ext_low
);

    typedef struct packed {
        logic [STAGES-1:0] sync;
        logic [STAGES-1:0] hist;
    } sync_t;

    sync_t state_d, state_q;

    always_comb begin
        state_d      = state_q;
        state_d.sync = {state_q.sync[STAGES-2:0], pin_n};
        state_d.hist = {state_q.hist[STAGES-2:0], drive};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q.sync <= '1;
            state_q.hist <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    // A low seen while the own pulse may still be in flight is discarded
    assign ext_low = !state_q.sync[STAGES-1] && !drive && !(|state_q.hist);

    AST_NO_ECHO_END: assert property (@(posedge clk) disable iff (!rst_n)
        $past(drive) |-> !ext_low) else $error("echo taken as end"); // R9

endmodule

// File: rtl/dma_eop_chan.sv
module dma_eop_chan #(
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_addr,
    input  logic              wr_cnt,
    input  logic [DATA_W-1:0] wdata,
    input  logic              step_addr,
    input  logic              step_cnt,
    input  logic              reload,
    output logic [DATA_W-1:0] cur_addr,
    output logic [DATA_W-1:0] cur_cnt,
    output logic              tc_hit
);

    typedef struct packed {
        logic [DATA_W-1:0] base_addr;
        logic [DATA_W-1:0] base_cnt;
        logic [DATA_W-1:0] cur_addr;
        logic [DATA_W-1:0] cur_cnt;
    } chan_t;

    chan_t chan_d, chan_q;

    always_comb begin
        chan_d = chan_q;
        if (reload) begin
            chan_d.cur_addr = chan_q.base_addr;
            chan_d.cur_cnt  = chan_q.base_cnt;
        end else begin
            if (step_addr) chan_d.cur_addr = chan_q.cur_addr + 1'b1;
            if (step_cnt)  chan_d.cur_cnt  = chan_q.cur_cnt - 1'b1;
        end
        if (wr_addr) begin
            chan_d.base_addr = wdata;
            chan_d.cur_addr  = wdata;
        end
        if (wr_cnt) begin
            chan_d.base_cnt = wdata;
            chan_d.cur_cnt  = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chan_q <= '0;
        else        chan_q <= chan_d;
    end

    assign cur_addr = chan_q.cur_addr;
    assign cur_cnt  = chan_q.cur_cnt;
    assign tc_hit   = step_cnt && (chan_q.cur_cnt == '0);

    AST_TC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (step_cnt && !reload && !wr_cnt && cur_cnt == '0) |=> (&cur_cnt)) else $error("no wrap"); // R2
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (step_cnt && !reload && !wr_cnt) |=> cur_cnt == DATA_W'($past(cur_cnt) - 1'b1)) else $error("bad step"); // R1
    AST_RELOAD_CNT: assert property (@(posedge clk) disable iff (!rst_n)
        (reload && !wr_cnt) |=> cur_cnt == $past(chan_q.base_cnt)) else $error("bad reload"); // R4

endmodule

// File: rtl/dma_eop_ctrl.sv
module dma_eop_ctrl #(
    parameter int unsigned NUM_CH = 4,
    parameter int unsigned DATA_W = 16,
    parameter int unsigned SYNC_STAGES = 2,
    localparam int unsigned CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CH_W-1:0]   cfg_ch,
    input  logic              cfg_sel,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  logic              mode_we,
    input  logic [CH_W-1:0]   mode_ch,
    input  logic              mode_autoinit,
    input  logic              m2m_en,
    input  logic              mask_we,
    input  logic [CH_W-1:0]   mask_ch,
    input  logic              mask_val,
    input  logic [NUM_CH-1:0] req_set,
    input  logic              act_valid,
    input  logic [CH_W-1:0]   act_ch,
    input  logic              xfer_stb,
    input  logic              eop_n_in,
    input  logic              status_rd,
    input  logic [CH_W-1:0]   rd_ch,
    output logic [DATA_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_cnt,
    output logic              eop_oe,
    output logic [NUM_CH-1:0] tc_status,
    output logic [NUM_CH-1:0] mask_o,
    output logic [NUM_CH-1:0] req_o
);

    import dma_eop_pkg::*;

    localparam logic [CH_W-1:0] DST_CH = CH_W'(M2M_DST_CH);
    localparam logic [CH_W-1:0] SRC_CH = CH_W'(M2M_SRC_CH);

    typedef struct packed {
        logic [NUM_CH-1:0] mask;
        logic [NUM_CH-1:0] req;
        logic [NUM_CH-1:0] tc;
        logic [NUM_CH-1:0] ai;
        logic              oe;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [NUM_CH-1:0] wr_a, wr_c, step_a, step_c, reload, tc_hit, end_vec;
    logic [DATA_W-1:0] addr_arr [NUM_CH];
    logic [DATA_W-1:0] cnt_arr  [NUM_CH];
    logic              ext_low, ext_end, int_end, end_any;
    logic [CH_W-1:0]   end_ch;

    dma_eop_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_n   (eop_n_in),
        .drive   (ctl_q.oe),
        .ext_low (ext_low)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
        localparam logic [CH_W-1:0] ID = CH_W'(g);
        logic in_pair;
        assign in_pair   = (ID == SRC_CH) || (ID == DST_CH);
        assign wr_a[g]   = cfg_we && cfg_ch == ID && cfg_sel == SEL_ADDR;
        assign wr_c[g]   = cfg_we && cfg_ch == ID && cfg_sel == SEL_COUNT;
        assign step_c[g] = xfer_stb && act_valid && (m2m_en ? (ID == DST_CH) : (act_ch == ID));
        assign step_a[g] = xfer_stb && act_valid && (m2m_en ? in_pair : (act_ch == ID));
        assign end_vec[g] = end_any && (end_ch == ID);
        assign reload[g]  = end_vec[g] && ctl_q.ai[g];

        dma_eop_chan #(.DATA_W(DATA_W)) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_addr   (wr_a[g]),
            .wr_cnt    (wr_c[g]),
            .wdata     (cfg_wdata),
            .step_addr (step_a[g]),
            .step_cnt  (step_c[g]),
            .reload    (reload[g]),
            .cur_addr  (addr_arr[g]),
            .cur_cnt   (cnt_arr[g]),
            .tc_hit    (tc_hit[g])
        );

        AST_END_REQ_CLR: assert property (@(posedge clk) disable iff (!rst_n)
            end_vec[g] |=> !req_o[g]) else $error("request kept"); // R3
        AST_END_TC_SET: assert property (@(posedge clk) disable iff (!rst_n)
            end_vec[g] |=> tc_status[g]) else $error("status not set"); // R5
        AST_MASK_SET: assert property (@(posedge clk) disable iff (!rst_n)
            (end_vec[g] && !ctl_q.ai[g]) |=> mask_o[g]) else $error("mask not set"); // R6
        AST_MASK_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
            (end_vec[g] && ctl_q.ai[g] && !(mask_we && mask_ch == ID)) |=> $stable(mask_o[g]))
            else $error("mask changed"); // R6
    end

    assign int_end = |tc_hit;
    assign ext_end = ext_low && act_valid;
    assign end_any = int_end || ext_end;
    assign end_ch  = m2m_en ? DST_CH : act_ch;

    always_comb begin
        ctl_d    = ctl_q;
        ctl_d.oe = int_end;
        if (mode_we)   ctl_d.ai[mode_ch]   = mode_autoinit;
        if (mask_we)   ctl_d.mask[mask_ch] = mask_val;
        ctl_d.req = ctl_q.req | req_set;
        if (status_rd) ctl_d.tc = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (end_vec[i]) begin
                ctl_d.tc[i]  = 1'b1;
                ctl_d.req[i] = 1'b0;
                if (!ctl_q.ai[i]) ctl_d.mask[i] = 1'b1;
            end
        end
        if (end_any && m2m_en) ctl_d.req[SRC_CH] = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q      <= '0;
            ctl_q.mask <= '1;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign eop_oe    = ctl_q.oe;
    assign tc_status = ctl_q.tc;
    assign mask_o    = ctl_q.mask;
    assign req_o     = ctl_q.req;
    assign rd_addr   = addr_arr[rd_ch];
    assign rd_cnt    = cnt_arr[rd_ch];

    AST_OE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        eop_oe |-> $past(xfer_stb && act_valid)) else $error("pulse without transfer"); // R2
    AST_M2M_PAIR_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (end_any && m2m_en) |=> !req_o[SRC_CH]) else $error("source request kept"); // R7

endmodule

// File: tb/test_dma_eop_ctrl.sv
module test_dma_eop_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int NCH = 4;
    localparam int DW = 16;

    logic clk = 0;
    logic rst_n = 0;
    logic cfg_we = 0, cfg_sel = 0, mode_we = 0, mode_ai = 0, m2m_en = 0;
    logic mask_we = 0, mask_val = 0, act_valid = 0, xfer_stb = 0, status_rd = 0;
    logic [1:0] cfg_ch = 0, mode_ch = 0, mask_ch = 0, act_ch = 0, rd_ch = 0;
    logic [DW-1:0] cfg_wdata = 0;
    logic [NCH-1:0] req_set = 0;
    logic ext_low = 0;
    logic eop_pin;
    logic [DW-1:0] rd_addr, rd_cnt;
    logic eop_oe;
    logic [NCH-1:0] tc_status, mask_o, req_o;

    int n_vec = 0, n_bad = 0;
    bit done = 0, use_model = 0;

    logic [DW-1:0] m_badr [NCH];
    logic [DW-1:0] m_bcnt [NCH];
    logic [DW-1:0] m_cadr [NCH];
    logic [DW-1:0] m_ccnt [NCH];
    logic [NCH-1:0] m_mask, m_req, m_tc, m_ai;
    logic m_oe;

    // open-drain line with pull-up
    assign eop_pin = (ext_low || eop_oe) ? 1'b0 : 1'b1;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_eop_ctrl #(.NUM_CH(NCH), .DATA_W(DW)) i_dma_eop_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .mode_we(mode_we), .mode_ch(mode_ch), .mode_autoinit(mode_ai),
        .m2m_en(m2m_en), .mask_we(mask_we), .mask_ch(mask_ch), .mask_val(mask_val),
        .req_set(req_set), .act_valid(act_valid), .act_ch(act_ch), .xfer_stb(xfer_stb),
        .eop_n_in(eop_pin), .status_rd(status_rd), .rd_ch(rd_ch), .rd_addr(rd_addr),
        .rd_cnt(rd_cnt), .eop_oe(eop_oe), .tc_status(tc_status), .mask_o(mask_o), .req_o(req_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] exp_step(input logic [DW-1:0] v, input bit up);
        return up ? DW'(v + 1'b1) : DW'(v - 1'b1);
    endfunction

    task automatic mdl_reset();
        for (int i = 0; i < NCH; i++) begin
            m_badr[i] = '0; m_bcnt[i] = '0; m_cadr[i] = '0; m_ccnt[i] = '0;
        end
        m_mask = '1; m_req = '0; m_tc = '0; m_ai = '0; m_oe = 0;
    endtask

    task automatic mdl_step();
        logic [NCH-1:0] ai_old;
        int ch;
        ai_old = m_ai;
        m_oe = 0;
        if (mode_we) m_ai[mode_ch] = mode_ai;
        if (mask_we) m_mask[mask_ch] = mask_val;
        m_req |= req_set;
        if (status_rd) m_tc = '0;
        if (xfer_stb && act_valid) begin
            ch = int'(act_ch);
            if (m_ccnt[ch] == '0) begin
                m_oe = 1; m_tc[ch] = 1; m_req[ch] = 0;
                if (ai_old[ch]) begin
                    m_cadr[ch] = m_badr[ch]; m_ccnt[ch] = m_bcnt[ch];
                end else begin
                    m_mask[ch] = 1; m_ccnt[ch] = '1; m_cadr[ch] = exp_step(m_cadr[ch], 1);
                end
            end else begin
                m_ccnt[ch] = exp_step(m_ccnt[ch], 0);
                m_cadr[ch] = exp_step(m_cadr[ch], 1);
            end
        end
        if (cfg_we) begin
            if (cfg_sel) begin m_bcnt[cfg_ch] = cfg_wdata; m_ccnt[cfg_ch] = cfg_wdata; end
            else         begin m_badr[cfg_ch] = cfg_wdata; m_cadr[cfg_ch] = cfg_wdata; end
        end
    endtask

    task automatic tick();
        @(posedge clk);
        if (use_model) mdl_step();
        @(negedge clk);
        cfg_we = 0; mode_we = 0; mask_we = 0; xfer_stb = 0; status_rd = 0; req_set = '0;
    endtask

    task automatic wr_cfg(input logic [1:0] ch, input logic sel, input logic [DW-1:0] v);
        cfg_we = 1; cfg_ch = ch; cfg_sel = sel; cfg_wdata = v; tick();
    endtask

    task automatic wr_mask(input logic [1:0] ch, input logic v);
        mask_we = 1; mask_ch = ch; mask_val = v; tick();
    endtask

    task automatic ext_pulse();
        ext_low = 1; tick(); ext_low = 0; tick(); tick();
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed1234));
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R10 reset state
        chk("R10 mask", 32'(mask_o), 32'hF);
        chk("R10 tc", 32'(tc_status), 0);
        chk("R10 req", 32'(req_o), 0);
        chk("R10 oe", 32'(eop_oe), 0);
        chk("R10 cnt", 32'(rd_cnt), 0);

        // R11 programming
        rd_ch = 2;
        wr_cfg(2, 0, 16'h1000);
        wr_cfg(2, 1, 16'd2);
        chk("R11 addr", 32'(rd_addr), 32'h1000);
        chk("R11 cnt", 32'(rd_cnt), 2);

        // R1, R2, R3, R5, R6 terminal count without autoinitialize
        wr_mask(2, 0);
        req_set = 4'b0100; tick();
        act_valid = 1; act_ch = 2;
        xfer_stb = 1; tick();
        chk("R1 cnt", 32'(rd_cnt), 1);
        chk("R1 addr", 32'(rd_addr), 32'h1001);
        chk("R2 no pulse", 32'(eop_oe), 0);
        xfer_stb = 1; tick();
        xfer_stb = 1; tick();
        chk("R2 wrap", 32'(rd_cnt), 32'hFFFF);
        chk("R2 pulse", 32'(eop_oe), 1);
        chk("R5 tc", 32'(tc_status[2]), 1);
        chk("R6 mask set", 32'(mask_o[2]), 1);
        chk("R3 req clr", 32'(req_o[2]), 0);
        tick();
        chk("R2 pulse end", 32'(eop_oe), 0);
        status_rd = 1; tick();
        chk("R5 read clr", 32'(tc_status), 0);

        // R4, R6 autoinitialize on channel 0
        act_valid = 0;
        mode_we = 1; mode_ch = 0; mode_ai = 1; tick();
        rd_ch = 0;
        wr_cfg(0, 0, 16'h0200);
        wr_cfg(0, 1, 16'd1);
        wr_mask(0, 0);
        act_valid = 1; act_ch = 0;
        xfer_stb = 1; tick();
        chk("R1 addr ch0", 32'(rd_addr), 32'h0201);
        xfer_stb = 1; tick();
        chk("R4 cnt reload", 32'(rd_cnt), 1);
        chk("R4 addr reload", 32'(rd_addr), 32'h0200);
        chk("R6 mask kept", 32'(mask_o[0]), 0);
        chk("R2 pulse ai", 32'(eop_oe), 1);

        // R9 echo of own pulse must not end again
        status_rd = 1; tick();
        req_set = 4'b0001; tick();
        tick(); tick(); tick();
        chk("R9 tc stays clear", 32'(tc_status[0]), 0);
        chk("R9 req kept", 32'(req_o[0]), 1);

        // R8 external end on channel 3
        act_valid = 0;
        rd_ch = 3;
        wr_cfg(3, 1, 16'd5);
        wr_mask(3, 0);
        req_set = 4'b1000; tick();
        act_valid = 1; act_ch = 3;
        ext_pulse();
        chk("R8 mask", 32'(mask_o[3]), 1);
        chk("R8 tc", 32'(tc_status[3]), 1);
        chk("R8 req", 32'(req_o[3]), 0);
        chk("R8 no pulse", 32'(eop_oe), 0);
        chk("R8 cnt kept", 32'(rd_cnt), 5);

        // R8 ignored without active service
        act_valid = 0;
        req_set = 4'b0010; tick();
        ext_pulse();
        tick();
        chk("R8 idle req", 32'(req_o[1]), 1);
        chk("R8 idle tc", 32'(tc_status[1]), 0);

        // R7 memory-to-memory
        wr_cfg(0, 0, 16'h0040);
        wr_cfg(0, 1, 16'd7);
        wr_cfg(1, 0, 16'h0080);
        wr_cfg(1, 1, 16'd1);
        wr_mask(1, 0);
        req_set = 4'b0011; tick();
        m2m_en = 1; act_valid = 1; act_ch = 3;
        xfer_stb = 1; tick();
        rd_ch = 0;
        chk("R7 src addr", 32'(rd_addr), 32'h0041);
        chk("R7 src cnt", 32'(rd_cnt), 7);
        rd_ch = 1; #1;
        chk("R7 dst addr", 32'(rd_addr), 32'h0081);
        chk("R7 dst cnt", 32'(rd_cnt), 0);
        xfer_stb = 1; tick();
        chk("R7 pulse", 32'(eop_oe), 1);
        chk("R7 tc1", 32'(tc_status[1]), 1);
        chk("R7 mask1", 32'(mask_o[1]), 1);
        chk("R7 req pair", 32'(req_o[1:0]), 0);
        chk("R7 dst wrap", 32'(rd_cnt), 32'hFFFF);
        m2m_en = 0; act_valid = 0;

        // random phase, checked against the bench model
        rst_n = 0; tick(); tick(); rst_n = 1;
        mdl_reset(); use_model = 1;
        for (int it = 0; it < 3000; it++) begin
            act_valid = ($urandom % 8) != 0;
            act_ch    = 2'($urandom);
            xfer_stb  = $urandom % 2;
            status_rd = ($urandom % 16) == 0;
            req_set   = (($urandom % 4) == 0) ? 4'($urandom) : 4'b0;
            mask_we   = ($urandom % 8) == 0; mask_ch = 2'($urandom); mask_val = $urandom % 2;
            mode_we   = ($urandom % 16) == 0; mode_ch = 2'($urandom); mode_ai = $urandom % 2;
            cfg_we    = ($urandom % 10) == 0; cfg_ch = 2'($urandom); cfg_sel = $urandom % 2;
            cfg_wdata = cfg_sel ? DW'($urandom % 4) : DW'($urandom);
            rd_ch     = 2'($urandom);
            tick();
            chk("R2 oe", 32'(eop_oe), 32'(m_oe));
            chk("R5 tc", 32'(tc_status), 32'(m_tc));
            chk("R6 mask", 32'(mask_o), 32'(m_mask));
            chk("R3 req", 32'(req_o), 32'(m_req));
            chk("R1 addr", 32'(rd_addr), 32'(m_cadr[rd_ch]));
            chk("R4 cnt", 32'(rd_cnt), 32'(m_ccnt[rd_ch]));
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule